// File: doc/BRIEF.md
# Three-Port Integer Register File

This block is the general-purpose register store of a small 32-bit load/store processor. It holds 32 words of 32 bits. Two read ports return register contents combinationally, so an execute stage can fetch both source operands in the cycle it needs them. One write port commits a destination value on the rising clock edge. Each port selects its entry with a 5-bit register number.

Entry 0 is a constant. It reads as zero on both ports at all times, and the block drops any write aimed at it. Software can therefore use entry 0 both as a zero source and as a destination whose result is thrown away. The block treats contents as raw bits. It applies no sign or type meaning and stores any 32-bit pattern exactly.

A same-cycle read of the entry being written returns the old contents by default. The `WRITE_THROUGH` parameter makes that read return the incoming data instead. An active-low asynchronous reset clears every entry.

Top module: `int_regfile`

## Requirements
- R1: The file has 32 entries of 32 bits, addressed 0 to 31 by 5-bit numbers. Each entry from 1 to 31 returns the value last written to it.
- R2: A write takes effect on the rising edge of `clk_i` only when `we_i` is 1. With `we_i` at 0, no entry changes, whatever `waddr_i` and `wdata_i` hold.
- R3: Reading address 0 returns 32'h0 on both read ports in every cycle.
- R4: A write addressed to entry 0 is discarded. Entry 0 still reads 0 afterwards, and all other entries keep their contents.
- R5: The read ports are combinational. `rdata_a_o` and `rdata_b_o` follow a change of `raddr_a_i` or `raddr_b_i` within the same cycle, with no clock edge.
- R6: With `WRITE_THROUGH` = 0 (the default), a read of the entry being written in the same cycle returns the old contents. The new value appears after the edge.
- R7: With `WRITE_THROUGH` = 1, a read of a nonzero entry being written in the same cycle returns `wdata_i`. A read of entry 0 still returns 0.
- R8: While `rst_ni` is 0, every entry is cleared to zero, without waiting for a clock edge.
- R9: The two read ports are independent. Each may select any entry, including the same one as the other port, and each returns the stored bits unchanged, including the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all entries |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Destination register number |
| wdata_i | input | 32 | Data to write |
| raddr_a_i | input | 5 | Register number for read port A |
| rdata_a_o | output | 32 | Contents of the entry selected on port A |
| raddr_b_i | input | 5 | Register number for read port B |
| rdata_b_o | output | 32 | Contents of the entry selected on port B |

## Verification
A corrupted or stale entry shows up on a read port as soon as either port selects it, with no added latency, because reads are combinational. A write that is lost, or that lands on the wrong entry, appears one edge later as a mismatch on a read of the target or of the entry it hit. A leak into entry 0 appears as a nonzero value on a zero-address read. A missing or wrong bypass shows up inside the writing cycle itself, so the same-cycle read is sampled before the edge and the same entry is read again just after it.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  parameter int unsigned RF_ENTRIES    = 32;
  parameter int unsigned RF_WIDTH      = 32;
  parameter int unsigned RF_READ_PORTS = 2;
endpackage

// File: rtl/regfile_storage.sv
module regfile_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                waddr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  // Entry 0 has no storage
  assign regs_o[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_entry
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (we_i && (waddr_i == ADDR_W'(i))) begin
        q <= wdata_i;
      end
    end
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/regfile_read_port.sv
module regfile_read_port #(
  parameter int unsigned NUM_REGS      = 32,
  parameter int unsigned DATA_W        = 32,
  parameter bit          WRITE_THROUGH = 1'b0,
  localparam int unsigned ADDR_W       = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                waddr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [ADDR_W-1:0]                raddr_i,
  output logic [DATA_W-1:0]                rdata_o
);
  logic hit;

  if (WRITE_THROUGH) begin : g_bypass
    assign hit = we_i && (waddr_i == raddr_i);
  end else begin : g_no_bypass
    logic unused_w;
    assign unused_w = we_i ^ (^waddr_i) ^ (^wdata_i);
    assign hit = 1'b0;
  end

  always_comb begin
    if (raddr_i == '0)  rdata_o = '0;
    else if (hit)       rdata_o = wdata_i;
    else                rdata_o = regs_i[raddr_i];
  end
endmodule

// File: rtl/int_regfile.sv
module int_regfile #(
  parameter int unsigned NUM_REGS      = regfile_pkg::RF_ENTRIES,
  parameter int unsigned DATA_W        = regfile_pkg::RF_WIDTH,
  parameter bit          WRITE_THROUGH = 1'b0,
  localparam int unsigned ADDR_W       = $clog2(NUM_REGS),
  localparam int unsigned NUM_RD       = regfile_pkg::RF_READ_PORTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][ADDR_W-1:0]   raddr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdata;

  assign raddr[0]  = raddr_a_i;
  assign raddr[1]  = raddr_b_i;
  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];

  regfile_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    regfile_read_port #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .WRITE_THROUGH(WRITE_THROUGH)
    ) u_port (
      .regs_i  (regs),
      .we_i    (we_i),
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .raddr_i (raddr[p]),
      .rdata_o (rdata[p])
    );
  end
endmodule

// File: rtl/regfile_checker.sv
module regfile_checker #(
  parameter int unsigned NUM_REGS      = 32,
  parameter int unsigned DATA_W        = 32,
  parameter bit          WRITE_THROUGH = 1'b0,
  localparam int unsigned ADDR_W       = $clog2(NUM_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [ADDR_W-1:0] raddr_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic [ADDR_W-1:0] raddr_b_i,
  input logic [DATA_W-1:0] rdata_b_o
);
  logic byp_a, byp_b;
  assign byp_a = WRITE_THROUGH && we_i && (waddr_i == raddr_a_i);
  assign byp_b = WRITE_THROUGH && we_i && (waddr_i == raddr_b_i);

  AST_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0)); // R3
  AST_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0)); // R3
  AST_WRITE_LANDS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(we_i) && $past(waddr_i) != '0 &&
     raddr_a_i == $past(waddr_i) && !byp_a) |-> (rdata_a_o == $past(wdata_i))); // R2
  AST_WRITE_LANDS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(we_i) && $past(waddr_i) != '0 &&
     raddr_b_i == $past(waddr_i) && !byp_b) |-> (rdata_b_o == $past(wdata_i))); // R9
  AST_HOLD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(we_i) && $stable(raddr_a_i) && !byp_a)
      |-> $stable(rdata_a_o)); // R1
  AST_BYPASS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_a && raddr_a_i != '0) |-> (rdata_a_o == wdata_i)); // R7
  AST_RESET_CLEAR_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(rst_ni) && !byp_a) |-> (rdata_a_o == '0)); // R8
endmodule

bind int_regfile regfile_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .WRITE_THROUGH(WRITE_THROUGH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .waddr_i(waddr_i),
  .wdata_i(wdata_i), .raddr_a_i(raddr_a_i), .rdata_a_o(rdata_a_o),
  .raddr_b_i(raddr_b_i), .rdata_b_o(rdata_b_o)
);

// File: tb/int_regfile_test.sv
`timescale 1ns/1ps
module int_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  waddr = '0, ra = '0, rb = '0;
  logic [31:0] wdata = '0;
  logic [31:0] da, db, wa, wb;
  logic [31:0] model [32];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  int_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .rdata_a_o(da), .raddr_b_i(rb), .rdata_b_o(db));

  int_regfile #(.WRITE_THROUGH(1'b1)) uut_wt (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .rdata_a_o(wa), .raddr_b_i(rb), .rdata_b_o(wb));

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    return (a == 5'd0) ? 32'h0 : model[a];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reads both ports on both instances with no write pending
  task automatic rd(input logic [4:0] a, input logic [4:0] b, input string req);
    @(negedge clk);
    we = 1'b0; ra = a; rb = b;
    #1;
    chk(req, da, exp_rd(a)); chk(req, db, exp_rd(b));
    chk(req, wa, exp_rd(a)); chk(req, wb, exp_rd(b));
  endtask

  // Write with same-cycle read of the target on port A
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d; ra = a;
    #1;
    chk("R6 old value same cycle", da, exp_rd(a));
    chk("R7 write-through same cycle", wa, (a == 5'd0) ? 32'h0 : d);
    @(posedge clk);
    if (a != 5'd0) model[a] = d;
    #0.5;
    chk("R2 value after edge", da, exp_rd(a));
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8 reset state
    for (int i = 0; i < 32; i += 2) rd(5'(i), 5'(i + 1), "R8 reset clears");
    // R1 fill all, incl. values with top bit set (R9)
    for (int i = 1; i < 32; i++) wr(5'(i), {i[0], 31'($urandom)});
    for (int i = 0; i < 32; i++) rd(5'(i), 5'(31 - i), "R1 R9 full readback");
    rd(5'd7, 5'd7, "R9 same entry both ports");
    // R4 write to entry 0
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, 5'd0, "R4 R3 entry 0 after write");
    for (int i = 1; i < 32; i++) rd(5'(i), 5'd0, "R4 others untouched");
    // R2 enable low
    @(negedge clk); we = 1'b0; waddr = 5'd9; wdata = ~model[9];
    @(posedge clk); @(negedge clk);
    rd(5'd9, 5'd9, "R2 no write without enable");
    // R5 combinational address change mid-cycle
    @(negedge clk);
    ra = 5'd3; rb = 5'd30; #0.5;
    chk("R5 comb read A", da, model[3]); chk("R5 comb read B", db, model[30]);
    ra = 5'd30; rb = 5'd3; #0.5;
    chk("R5 comb read A", da, model[30]); chk("R5 comb read B", db, model[3]);
    // Random traffic
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(1, 0) == 1)
        wr(5'($urandom_range(31, 0)), $urandom);
      else
        rd(5'($urandom_range(31, 0)), 5'($urandom_range(31, 0)), "R1 random read");
    end
    // R8 asynchronous reset mid-run, checked before any edge
    @(negedge clk); ra = 5'd5; rb = 5'd31;
    rst_n = 1'b0; #0.5;
    chk("R8 async clear A", da, 32'h0); chk("R8 async clear B", db, 32'h0);
    chk("R8 async clear wt", wb, 32'h0);
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    @(negedge clk); rst_n = 1'b1;
    rd(5'd5, 5'd31, "R8 after release");
    wr(5'd12, 32'h8000_0001);
    rd(5'd12, 5'd0, "R9 R3 sign bit kept");
    finish_run();
  end
endmodule